// File: doc/BRIEF.md
# BCD calendar clock counter

This block is a real-time clock core. A slow tick enable (nominally 32768 pulses per second) drives a sub-second prescaler. Each time the prescaler completes, the calendar advances by one second. Seconds, minutes, hours (24-hour), day of month, month, two-digit year (2000 to 2099) and weekday are each kept as one packed-BCD byte.

Software uses a small byte-wide register bus. It reads and writes the seven time fields, starts and stops the clock through a control register, and polls a status register. The status register shows whether the clock runs, raises a busy warning during the last tick period before each one-second update, and keeps sticky flags for new seconds, minutes, hours and days. Software clears a flag by writing a one to its bit.

Read data follows the address combinationally. A write takes effect on the clock edge on which the strobe (`bus_sel` and `bus_wr` both high) is sampled. The external reset is asynchronous and active-low. Its release is synchronised inside the block, which takes two clock edges.

Top module: `bcd_calendar_rtc`

## Requirements
- R1: After reset the fields read seconds 0x00, minutes 0x00, hours 0x00, day 0x01, month 0x01, year 0x00 and weekday 0x00. The control register (0x40) and the status register (0x44) read 0x00.
- R2: The time fields sit at byte offsets seconds 0x00, minutes 0x04, hours 0x08, day 0x0C, month 0x10, year 0x14 and weekday 0x18. A write keeps only the field's valid bits: seconds and minutes 7 bits (mask 0x7F), hours and day 6 bits (0x3F), month 5 bits (0x1F), weekday 3 bits (0x07), year all 8 bits.
- R3: With control bit 0 at 0, tick enables change no time field and status bit 1 reads 0. With control bit 0 at 1, status bit 1 reads 1.
- R4: On each second, seconds step in BCD and wrap from 0x59 to 0x00. A seconds wrap steps minutes, which wrap from 0x59 to 0x00. A minutes wrap steps hours, which wrap from 0x23 to 0x00.
- R5: An hours wrap advances the day of month. Once the day has reached the length of its month, the day returns to 0x01 and the month steps. February has 29 days when the year value is a multiple of 4, and 28 days otherwise. Months wrap from 0x12 to 0x01, and the year wraps from 0x99 to 0x00 when the month wraps.
- R6: The weekday counts 0 to 6. It steps together with every day-of-month advance, and 6 is followed by 0.
- R7: Status bit 0 (busy) is 1 while the clock runs and the prescaler sits in the last tick period of the current second. The busy bit drops on the tick that performs the update.
- R8: Status bits 2, 3, 4 and 5 are sticky flags for a new second, minute, hour and day. A flag stays set until software writes 1 to that bit of the status register. If an event and its clear fall in the same cycle, the event wins.
- R9: A write to any time field restarts the prescaler at zero. No update happens in the cycle of the write, so the next second completes a full TICKS_PER_SEC tick enables after the write.
- R10: Control bit 3 (12/24-hour select) is stored and read back but has no effect: hours still run in 24-hour form. Control bits other than 0 and 3 read 0.
- R11: Reads of offsets outside the nine defined registers, including misaligned offsets, return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised internally |
| tick_en | input | 1 | One-cycle enable per prescaler tick (32768 Hz nominal) |
| bus_sel | input | 1 | Register bus select |
| bus_wr | input | 1 | Write strobe, effective together with bus_sel |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |

## Verification
The bench builds the block with TICKS_PER_SEC set to 4. A full second then takes only four tick enables, and the busy window and the prescaler restart can be placed on exact ticks.

With seconds this cheap, the bench covers every rollover point directly:
- every value of seconds, minutes and hours;
- the last day of every month in all hundred years;
- 28 February in every year, including the leap cases;
- every weekday.

Each expected calendar is worked out in plain integer arithmetic in the bench.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int unsigned N_FIELDS = 7;

  localparam int unsigned F_SEC  = 0;
  localparam int unsigned F_MIN  = 1;
  localparam int unsigned F_HOUR = 2;
  localparam int unsigned F_DAY  = 3;
  localparam int unsigned F_MON  = 4;
  localparam int unsigned F_YEAR = 5;
  localparam int unsigned F_WDAY = 6;

  localparam logic [7:0] OFS_CTRL = 8'h40;
  localparam logic [7:0] OFS_STAT = 8'h44;

  typedef logic [N_FIELDS-1:0][7:0] cal_t;

  localparam cal_t CAL_RESET = {8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

  function automatic logic [7:0] field_mask(input logic [2:0] idx);
    case (idx)
      3'd0, 3'd1: return 8'h7F;
      3'd2, 3'd3: return 8'h3F;
      3'd4:       return 8'h1F;
      3'd5:       return 8'hFF;
      3'd6:       return 8'h07;
      default:    return 8'h00;
    endcase
  endfunction

  function automatic logic is_time_ofs(input logic [7:0] ofs);
    return (ofs[7:5] == 3'b000) && (ofs[1:0] == 2'b00) && (ofs[4:2] != 3'b111);
  endfunction

  function automatic logic [7:0] bcd_to_bin(input logic [7:0] v);
    return ({4'b0, v[7:4]} * 8'd10) + {4'b0, v[3:0]};
  endfunction

  function automatic logic [7:0] bcd_step(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [7:0] month_days(input logic [7:0] mon_bin,
                                            input logic [7:0] yr_bin);
    case (mon_bin)
      8'd2:                    return (yr_bin[1:0] == 2'b00) ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11: return 8'd30;
      default:                 return 8'd31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned TICKS_PER_SEC = 32768,
  parameter int unsigned CNT_W         = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             run,
  input  logic             restart,
  output logic             sec_pulse,
  output logic             busy,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS_PER_SEC - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             at_last;

  always_comb begin
    at_last   = (cnt_q == LAST);
    busy      = run & at_last;
    sec_pulse = run & tick_en & at_last & ~restart;
    cnt_en    = restart | (run & tick_en);
    if (restart || at_last) cnt_d = '0;
    else                    cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sec_pulse,
  input  logic       wr_en,
  input  logic [2:0] wr_idx,
  input  logic [7:0] wr_data,
  output cal_t       cal,
  output logic       min_roll,
  output logic       hour_roll,
  output logic       day_roll
);

  cal_t cal_q, cal_d;
  logic cal_en;
  logic s_wrap, m_wrap, h_wrap, d_wrap, mo_wrap, y_wrap;

  always_comb begin
    s_wrap  = bcd_to_bin(cal_q[F_SEC])  >= 8'd59;
    m_wrap  = bcd_to_bin(cal_q[F_MIN])  >= 8'd59;
    h_wrap  = bcd_to_bin(cal_q[F_HOUR]) >= 8'd23;
    d_wrap  = bcd_to_bin(cal_q[F_DAY])  >=
              month_days(bcd_to_bin(cal_q[F_MON]), bcd_to_bin(cal_q[F_YEAR]));
    mo_wrap = bcd_to_bin(cal_q[F_MON])  >= 8'd12;
    y_wrap  = bcd_to_bin(cal_q[F_YEAR]) >= 8'd99;

    min_roll  = sec_pulse & s_wrap;
    hour_roll = min_roll & m_wrap;
    day_roll  = hour_roll & h_wrap;
  end

  always_comb begin
    cal_d  = cal_q;
    cal_en = wr_en | sec_pulse;
    if (wr_en) begin
      cal_d[wr_idx] = wr_data & field_mask(wr_idx);
    end else if (sec_pulse) begin
      cal_d[F_SEC] = s_wrap ? 8'h00 : bcd_step(cal_q[F_SEC]);
      if (min_roll)
        cal_d[F_MIN] = m_wrap ? 8'h00 : bcd_step(cal_q[F_MIN]);
      if (hour_roll)
        cal_d[F_HOUR] = h_wrap ? 8'h00 : bcd_step(cal_q[F_HOUR]);
      if (day_roll) begin
        cal_d[F_DAY]  = d_wrap ? 8'h01 : bcd_step(cal_q[F_DAY]);
        cal_d[F_WDAY] = (cal_q[F_WDAY] >= 8'd6) ? 8'h00 : cal_q[F_WDAY] + 8'd1;
        if (d_wrap) begin
          cal_d[F_MON] = mo_wrap ? 8'h01 : bcd_step(cal_q[F_MON]);
          if (mo_wrap)
            cal_d[F_YEAR] = y_wrap ? 8'h00 : bcd_step(cal_q[F_YEAR]);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cal_q <= CAL_RESET;
    else if (cal_en) cal_q <= cal_d;
  end

  assign cal = cal_q;

endmodule

// File: rtl/rtc_regs.sv
module rtc_regs
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_stb,
  input  logic [7:0] addr,
  input  logic [7:0] wdata,
  input  logic       sec_pulse,
  input  logic       min_roll,
  input  logic       hour_roll,
  input  logic       day_roll,
  input  logic       busy,
  input  cal_t       cal,
  output logic       run,
  output logic [3:0] events,
  output logic [7:0] rdata
);

  logic       run_q, run_d, mode_q, mode_d, ctrl_en;
  logic [3:0] ev_q, ev_d, ev_set, ev_clr;
  logic       ev_en, stat_wr;

  always_comb begin
    ctrl_en = wr_stb && (addr == OFS_CTRL);
    run_d   = wdata[0];
    mode_d  = wdata[3];
    stat_wr = wr_stb && (addr == OFS_STAT);
    ev_set  = {day_roll, hour_roll, min_roll, sec_pulse};
    ev_clr  = stat_wr ? wdata[5:2] : 4'b0000;
    ev_d    = (ev_q & ~ev_clr) | ev_set;
    ev_en   = stat_wr | (|ev_set);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      mode_q <= 1'b0;
    end else if (ctrl_en) begin
      run_q  <= run_d;
      mode_q <= mode_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ev_q <= 4'b0000;
    else if (ev_en) ev_q <= ev_d;
  end

  always_comb begin
    if (is_time_ofs(addr))     rdata = cal[addr[4:2]];
    else if (addr == OFS_CTRL) rdata = {4'b0000, mode_q, 2'b00, run_q};
    else if (addr == OFS_STAT) rdata = {2'b00, ev_q, run_q, busy};
    else                       rdata = 8'h00;
  end

  assign run    = run_q;
  assign events = ev_q;

endmodule

// File: rtl/bcd_calendar_rtc.sv
module bcd_calendar_rtc
  import rtc_pkg::*;
#(
  parameter int unsigned TICKS_PER_SEC = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       bus_sel,
  input  logic       bus_wr,
  input  logic [7:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata
);

  localparam int unsigned PRESC_W = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;

  logic [1:0]         rst_sync_q;
  logic               core_rst_n;
  logic               wr_stb, time_wr;
  logic               run, busy, sec_pulse;
  logic               min_roll, hour_roll, day_roll;
  logic [PRESC_W-1:0] presc;
  logic [3:0]         events;
  cal_t               cal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  always_comb begin
    wr_stb  = bus_sel & bus_wr;
    time_wr = wr_stb & is_time_ofs(bus_addr);
  end

  rtc_prescaler #(
    .TICKS_PER_SEC(TICKS_PER_SEC),
    .CNT_W        (PRESC_W)
  ) u_presc (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .tick_en  (tick_en),
    .run      (run),
    .restart  (time_wr),
    .sec_pulse(sec_pulse),
    .busy     (busy),
    .count    (presc)
  );

  rtc_calendar u_cal (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .sec_pulse(sec_pulse),
    .wr_en    (time_wr),
    .wr_idx   (bus_addr[4:2]),
    .wr_data  (bus_wdata),
    .cal      (cal),
    .min_roll (min_roll),
    .hour_roll(hour_roll),
    .day_roll (day_roll)
  );

  rtc_regs u_regs (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .wr_stb   (wr_stb),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .sec_pulse(sec_pulse),
    .min_roll (min_roll),
    .hour_roll(hour_roll),
    .day_roll (day_roll),
    .busy     (busy),
    .cal      (cal),
    .run      (run),
    .events   (events),
    .rdata    (bus_rdata)
  );

endmodule

// File: rtl/rtc_checker.sv
module rtc_checker
  import rtc_pkg::*;
#(
  parameter int unsigned PRESC_W = 15
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_sel,
  input logic               bus_wr,
  input logic [7:0]         bus_addr,
  input logic [7:0]         bus_wdata,
  input logic               run,
  input logic               busy,
  input logic               sec_pulse,
  input logic               time_wr,
  input logic [PRESC_W-1:0] presc,
  input cal_t               cal,
  input logic [3:0]         events
);

  logic sec_flag_clr;
  assign sec_flag_clr = bus_sel && bus_wr && (bus_addr == OFS_STAT) && bus_wdata[2];

  // R7
  pulse_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_pulse |-> busy);

  // R3
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !time_wr) |=> $stable(cal));

  // R4
  sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_pulse && cal[F_SEC] == 8'h59) |=> (cal[F_SEC] == 8'h00));

  // R4
  hour_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_pulse && cal[F_SEC] == 8'h59 && cal[F_MIN] == 8'h59 && cal[F_HOUR] == 8'h23)
      |=> (cal[F_HOUR] == 8'h00));

  // R9
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    time_wr |=> (presc == '0));

  // R8
  sticky_sec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (events[0] && !sec_flag_clr) |=> events[0]);

endmodule

bind bcd_calendar_rtc rtc_checker #(.PRESC_W(PRESC_W)) u_rtc_chk (
  .clk      (clk),
  .rst_n    (core_rst_n),
  .bus_sel  (bus_sel),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .run      (run),
  .busy     (busy),
  .sec_pulse(sec_pulse),
  .time_wr  (time_wr),
  .presc    (presc),
  .cal      (cal),
  .events   (events)
);

// File: tb/test_bcd_calendar_rtc.sv
module test_bcd_calendar_rtc;

  localparam int TPS = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_en;
  logic       bus_sel;
  logic       bus_wr;
  logic [7:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  bcd_calendar_rtc #(.TICKS_PER_SEC(TPS)) i_bcd_calendar_rtc (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata)
  );

  function automatic logic [7:0] to_bcd(input int n);
    return 8'(((n / 10) << 4) | (n % 10));
  endfunction

  function automatic int mdays(input int mo, input int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b0;
    end
  endtask

  task automatic set_time(input int y, input int mo, input int d, input int wd,
                          input int h, input int mi, input int s);
    bus_write(8'h14, to_bcd(y));
    bus_write(8'h10, to_bcd(mo));
    bus_write(8'h0C, to_bcd(d));
    bus_write(8'h18, to_bcd(wd));
    bus_write(8'h08, to_bcd(h));
    bus_write(8'h04, to_bcd(mi));
    bus_write(8'h00, to_bcd(s));
  endtask

  task automatic check_time(input string req, input int y, input int mo, input int d,
                            input int wd, input int h, input int mi, input int s);
    logic [7:0] v;
    bus_read(8'h00, v); check(req, "seconds", v, to_bcd(s));
    bus_read(8'h04, v); check(req, "minutes", v, to_bcd(mi));
    bus_read(8'h08, v); check(req, "hours",   v, to_bcd(h));
    bus_read(8'h0C, v); check(req, "day",     v, to_bcd(d));
    bus_read(8'h10, v); check(req, "month",   v, to_bcd(mo));
    bus_read(8'h14, v); check(req, "year",    v, to_bcd(y));
    bus_read(8'h18, v); check(req, "weekday", v, to_bcd(wd));
  endtask

  // load a time, let one second pass, compare with the arithmetic successor
  task automatic step_check(input string req, input int y, input int mo, input int d,
                            input int wd, input int h, input int mi, input int s);
    set_time(y, mo, d, wd, h, mi, s);
    ticks(TPS);
    s++;
    if (s == 60) begin
      s = 0; mi++;
      if (mi == 60) begin
        mi = 0; h++;
        if (h == 24) begin
          h = 0; wd = (wd + 1) % 7; d++;
          if (d > mdays(mo, y)) begin
            d = 1; mo++;
            if (mo == 13) begin mo = 1; y = (y + 1) % 100; end
          end
        end
      end
    end
    check_time(req, y, mo, d, wd, h, mi, s);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    rst_n = 1'b0; tick_en = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
    bus_addr = 8'h00; bus_wdata = 8'h00;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state
    check_time("R1", 0, 1, 1, 0, 0, 0, 0);
    bus_read(8'h40, v); check("R1", "control", v, 8'h00);
    bus_read(8'h44, v); check("R1", "status", v, 8'h00);

    // R2 field width masking
    bus_write(8'h00, 8'hFF); bus_read(8'h00, v); check("R2", "seconds mask", v, 8'h7F);
    bus_write(8'h04, 8'hFF); bus_read(8'h04, v); check("R2", "minutes mask", v, 8'h7F);
    bus_write(8'h08, 8'hFF); bus_read(8'h08, v); check("R2", "hours mask", v, 8'h3F);
    bus_write(8'h0C, 8'hFF); bus_read(8'h0C, v); check("R2", "day mask", v, 8'h3F);
    bus_write(8'h10, 8'hFF); bus_read(8'h10, v); check("R2", "month mask", v, 8'h1F);
    bus_write(8'h14, 8'hFF); bus_read(8'h14, v); check("R2", "year mask", v, 8'hFF);
    bus_write(8'h18, 8'hFF); bus_read(8'h18, v); check("R2", "weekday mask", v, 8'h07);

    // R3 stopped clock holds time
    set_time(21, 7, 4, 3, 10, 20, 30);
    ticks(2 * TPS);
    check_time("R3", 21, 7, 4, 3, 10, 20, 30);
    bus_read(8'h44, v); check("R3", "status stopped", v, 8'h00);
    bus_write(8'h40, 8'h01);
    bus_read(8'h44, v); check("R3", "status running", v & 8'h02, 8'h02);

    // R11 unmapped offsets
    bus_read(8'h1C, v); check("R11", "offset 0x1C", v, 8'h00);
    bus_read(8'h48, v); check("R11", "offset 0x48", v, 8'h00);
    bus_read(8'h02, v); check("R11", "offset 0x02", v, 8'h00);
    bus_read(8'h41, v); check("R11", "offset 0x41", v, 8'h00);

    // R7 busy window on the final tick of a second
    set_time(24, 3, 15, 5, 8, 0, 0);
    ticks(TPS - 1);
    bus_read(8'h44, v); check("R7", "busy in last tick", v & 8'h03, 8'h03);
    bus_read(8'h00, v); check("R7", "seconds before update", v, 8'h00);
    ticks(1);
    bus_read(8'h44, v); check("R7", "busy after update", v & 8'h03, 8'h02);
    bus_read(8'h00, v); check("R7", "seconds after update", v, 8'h01);

    // R9 time write restarts the prescaler
    set_time(24, 3, 15, 5, 0, 0, 10);
    ticks(TPS - 1);
    bus_write(8'h04, 8'h05);
    ticks(TPS - 1);
    bus_read(8'h00, v); check("R9", "seconds held after restart", v, 8'h10);
    ticks(1);
    bus_read(8'h00, v); check("R9", "seconds after full second", v, 8'h11);

    // R8 sticky event flags, write-one-to-clear
    bus_write(8'h44, 8'h3C);
    bus_read(8'h44, v); check("R8", "all cleared", v, 8'h02);
    set_time(24, 3, 15, 5, 12, 34, 58);
    ticks(TPS);
    bus_read(8'h44, v); check("R8", "second flag only", v, 8'h06);
    bus_write(8'h44, 8'h04);
    bus_read(8'h44, v); check("R8", "second flag cleared", v, 8'h02);
    set_time(24, 3, 15, 5, 23, 59, 59);
    ticks(TPS);
    bus_read(8'h44, v); check("R8", "all four flags", v, 8'h3E);
    ticks(2);
    bus_read(8'h44, v); check("R8", "flags sticky", v, 8'h3E);
    bus_write(8'h44, 8'h08);
    bus_read(8'h44, v); check("R8", "minute flag cleared alone", v, 8'h36);
    bus_write(8'h44, 8'h3C);

    // R10 mode bit stored, no 12-hour behaviour
    bus_write(8'h40, 8'hFF);
    bus_read(8'h40, v); check("R10", "control readback", v, 8'h09);
    step_check("R10", 50, 5, 5, 2, 23, 59, 59);
    step_check("R10", 50, 5, 5, 2, 12, 59, 59);
    bus_write(8'h40, 8'h01);

    // R4 sweep seconds, minutes, hours
    for (int s = 0; s < 60; s++) step_check("R4", 24, 3, 15, 5, 5, 6, s);
    for (int m = 0; m < 60; m++) step_check("R4", 24, 3, 15, 5, 7, m, 59);
    for (int h = 0; h < 24; h++) step_check("R4", 24, 3, 15, 5, h, 59, 59);

    // R6 weekday wrap with each day advance
    for (int w = 0; w < 7; w++) step_check("R6", 30, 6, 10, w, 23, 59, 59);

    // R5 last day of every month in every year, and 28 February
    for (int y = 0; y < 100; y++) begin
      for (int mo = 1; mo <= 12; mo++)
        step_check("R5", y, mo, mdays(mo, y), (y + mo) % 7, 23, 59, 59);
      step_check("R5", y, 2, 28, y % 7, 23, 59, 59);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule